// File: doc/BRIEF.md
# Register-Mapped SPI Master

A bus-attached SPI master that moves 8-bit frames between two FIFOs and one full-duplex serial link. Software sets up clock polarity, clock phase and the bus-clock divider while the controller is off. It pushes bytes into the transmit FIFO, turns the controller on, and collects one received byte for every byte sent. Select lines are plain register bits that drive active-low pins. Software asserts them around a transfer.

The register port is a single-cycle 32-bit bus: a write takes effect at the clock edge where it is presented, and read data appears registered on the following cycle. Reading the receive data location pops that FIFO. The fill levels of both FIFOs can be read directly. Each FIFO also has a watermark register that only accepts values the FIFO can hold, so software can find the depth by writing large values and reading them back. Two latched, maskable level conditions drive one interrupt line. Software clears them through a write-one-to-clear location.

Top module: `spi_host_top`

## Requirements
- R1: After reset, every select pin reads 1, SCLK is 0, the interrupt line is 0, and the status and level registers read 0.
- R2: The control register holds clock polarity at bit 7 and clock phase at bit 6. Writes to control (0x000) and divider (0x010) are ignored while the enable bit is 1, and readback then shows the earlier value.
- R3: A watermark write (transmit 0x014, receive 0x018) is stored only if the value is below the FIFO depth of 32. Otherwise the register keeps its previous value.
- R4: The transmit level (0x01C) counts queued bytes. A push to transmit data (0x400) while 32 bytes are queued is dropped.
- R5: Reading receive data (0x800) with the receive FIFO empty returns 0. A non-empty read returns the oldest byte and removes it.
- R6: Each SCLK half period lasts D/2 bus clocks. D is the divider value with bit 0 cleared, and 2 is used when that result is below 2.
- R7: While idle, SCLK rests at the polarity bit. With phase 0, data is sampled on the first edge of each bit. With phase 1, it is sampled on the second edge. With MISO looped from MOSI, every mode returns the sent byte.
- R8: Frames leave on MOSI most significant bit first.
- R9: Every transmitted byte pushes exactly one byte into the receive FIFO, whose level (0x020) counts it.
- R10: Setting bit i of the select register (0x00C) drives cs_n[i] low. A cleared bit drives it high.
- R11: Status (0x024) bit 0 reads 1 while a frame is shifting or the transmit FIFO holds data.
- R12: Raw status (0x034) bit 0 latches when transmit level is at or below its watermark. Bit 4 latches when receive level exceeds its watermark. Masked status (0x030) is raw AND mask (0x02C). Writing 1s to clear (0x038) drops the matching latched bits. irq is high while any masked bit is set.
- R13: Enable (0x008) bit 0 gates shifting. While it is 0, queued bytes stay queued and nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and serial reference clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low selects |
| irq | output | 1 | Level interrupt |

## Verification
A broken shift counter or edge selector shows up at the pins in the first frame. SCLK half periods come out the wrong length, the idle level does not match polarity, or the looped byte returns rotated or inverted. This is visible within 16 half periods. A wrong FIFO pointer or count shows in the very next level read, or when the 32-byte sequence is read back in order. A stuck interrupt latch shows on irq two cycles after the clear write.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int FRAME_W = 8;
  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_EN    = 12'h008;
  localparam logic [11:0] OFS_SEL   = 12'h00C;
  localparam logic [11:0] OFS_DIV   = 12'h010;
  localparam logic [11:0] OFS_TXWM  = 12'h014;
  localparam logic [11:0] OFS_RXWM  = 12'h018;
  localparam logic [11:0] OFS_TXLV  = 12'h01C;
  localparam logic [11:0] OFS_RXLV  = 12'h020;
  localparam logic [11:0] OFS_STAT  = 12'h024;
  localparam logic [11:0] OFS_MASK  = 12'h02C;
  localparam logic [11:0] OFS_MSTAT = 12'h030;
  localparam logic [11:0] OFS_RAW   = 12'h034;
  localparam logic [11:0] OFS_CLR   = 12'h038;
  localparam logic [11:0] OFS_TXD   = 12'h400;
  localparam logic [11:0] OFS_RXD   = 12'h800;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  assign dout  = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("push into full fifo");
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("pop from empty fifo");
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH))
    else $error("fifo count beyond depth");
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               tx_empty_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_pop_o,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               active_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_data_o
);
  localparam int EDGES = 2 * FRAME_W;
  localparam int EW    = $clog2(EDGES);

  logic [DIV_W-1:0]   half, tick_cnt;
  logic [EW-1:0]      edge_idx;
  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic               tick, leading, last_edge, sample_edge;

  always_comb begin
    half = (div_i & ~DIV_W'(1)) >> 1;
    if (half == '0) half = DIV_W'(1);
  end

  assign tick        = active_o && (tick_cnt == half - 1'b1);
  assign leading     = !edge_idx[0];
  assign last_edge   = (edge_idx == EW'(EDGES - 1));
  assign sample_edge = (leading != cpha_i);
  assign tx_pop_o    = en_i && !active_o && !tx_empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o  <= 1'b0;
      tick_cnt  <= '0;
      edge_idx  <= '0;
      sclk_o    <= 1'b0;
      mosi_o    <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      done_o    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        active_o <= 1'b0;
        sclk_o   <= cpol_i;
        tick_cnt <= '0;
        edge_idx <= '0;
      end else if (!active_o) begin
        sclk_o <= cpol_i;
        if (!tx_empty_i) begin
          active_o <= 1'b1;
          tick_cnt <= '0;
          edge_idx <= '0;
          if (!cpha_i) begin
            mosi_o <= tx_data_i[FRAME_W-1];
            tx_sh  <= tx_data_i << 1;
          end else begin
            tx_sh  <= tx_data_i;
          end
        end
      end else if (tick) begin
        tick_cnt <= '0;
        sclk_o   <= ~sclk_o;
        edge_idx <= edge_idx + 1'b1;
        if (sample_edge) begin
          rx_sh <= {rx_sh[FRAME_W-2:0], miso_i};
        end else if (!last_edge) begin
          mosi_o <= tx_sh[FRAME_W-1];
          tx_sh  <= tx_sh << 1;
        end
        if (last_edge) begin
          active_o  <= 1'b0;
          done_o    <= 1'b1;
          rx_data_o <= cpha_i ? {rx_sh[FRAME_W-2:0], miso_i} : rx_sh;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  // R13: a byte leaves the queue only while enabled and when one is present
  p_pop_gated_r13: assert property (@(posedge clk) disable iff (rst)
    tx_pop_o |=> active_o)
    else $error("pop without frame start");
  // R7: idle clock rests at the selected polarity one cycle after activity ends
  p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
    (!active_o && $past(!active_o) && $stable(cpol_i) && $past(en_i)) |-> (sclk_o == cpol_i))
    else $error("idle sclk level wrong");
endmodule

// File: rtl/spi_host_top.sv
module spi_host_top
  import spi_host_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int DEPTH = 32,
  parameter int DIV_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [11:0]    addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic             en_q, cpol_q, cpha_q;
  logic [DIV_W-1:0] div_q;
  logic [TW-1:0]    tx_wm, rx_wm;
  logic             msk_tx, msk_rx, raw_tx, raw_rx;

  logic               tx_push, tx_pop, tx_full, tx_empty;
  logic               rx_push, rx_pop, rx_full, rx_empty;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_frame;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic               eng_active, eng_done;
  logic               wr_wm_ok, clr_tx, clr_rx;

  assign wr_wm_ok = (wdata < 32'(DEPTH));
  assign tx_push  = wr_en && (addr == OFS_TXD) && !tx_full;
  assign rx_pop   = rd_en && (addr == OFS_RXD) && !rx_empty;
  assign rx_push  = eng_done && !rx_full;
  assign clr_tx   = wr_en && (addr == OFS_CLR) && wdata[0];
  assign clr_rx   = wr_en && (addr == OFS_CLR) && wdata[4];

  spi_byte_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(wdata[FRAME_W-1:0]),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_byte_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_frame),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .en_i(en_q), .cpol_i(cpol_q), .cpha_i(cpha_q),
    .div_i(div_q), .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .active_o(eng_active),
    .done_o(eng_done), .rx_data_o(rx_frame));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      div_q <= '0; tx_wm <= '0; rx_wm <= '0;
      msk_tx <= 1'b0; msk_rx <= 1'b0;
      cs_n <= '1;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL: if (!en_q) begin cpol_q <= wdata[7]; cpha_q <= wdata[6]; end
        OFS_EN:   en_q <= wdata[0];
        OFS_SEL:  cs_n <= ~wdata[NCS-1:0];
        OFS_DIV:  if (!en_q) div_q <= wdata[DIV_W-1:0];
        OFS_TXWM: if (wr_wm_ok) tx_wm <= wdata[TW-1:0];
        OFS_RXWM: if (wr_wm_ok) rx_wm <= wdata[TW-1:0];
        OFS_MASK: begin msk_tx <= wdata[0]; msk_rx <= wdata[4]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_tx <= 1'b0;
      raw_rx <= 1'b0;
      irq    <= 1'b0;
    end else begin
      raw_tx <= (raw_tx && !clr_tx) || (tx_cnt <= CW'(tx_wm));
      raw_rx <= (raw_rx && !clr_rx) || (rx_cnt >  CW'(rx_wm));
      irq    <= (raw_tx && msk_tx) || (raw_rx && msk_rx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_CTRL:  rdata <= {24'b0, cpol_q, cpha_q, 6'b0};
        OFS_EN:    rdata <= {31'b0, en_q};
        OFS_SEL:   rdata <= 32'(~cs_n);
        OFS_DIV:   rdata <= 32'(div_q);
        OFS_TXWM:  rdata <= 32'(tx_wm);
        OFS_RXWM:  rdata <= 32'(rx_wm);
        OFS_TXLV:  rdata <= 32'(tx_cnt);
        OFS_RXLV:  rdata <= 32'(rx_cnt);
        OFS_STAT:  rdata <= {31'b0, eng_active || !tx_empty};
        OFS_MASK:  rdata <= {27'b0, msk_rx, 3'b0, msk_tx};
        OFS_MSTAT: rdata <= {27'b0, raw_rx && msk_rx, 3'b0, raw_tx && msk_tx};
        OFS_RAW:   rdata <= {27'b0, raw_rx, 3'b0, raw_tx};
        OFS_RXD:   rdata <= rx_empty ? 32'b0 : 32'(rx_head);
        default:   rdata <= '0;
      endcase
    end
  end

  // R2: configuration does not move while the controller is on
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q)) |-> ($stable(cpol_q) && $stable(cpha_q) && $stable(div_q)))
    else $error("config changed while enabled");
  // R9: a received byte enters the queue only at the end of a frame
  p_rx_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_done) |-> $past(eng_active))
    else $error("frame done without active frame");
endmodule

// File: tb/tb_spi_host_top.sv
module tb_spi_host_top;
  import spi_host_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;
  logic irq;
  logic invert = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  assign miso = invert ? ~mosi : mosi;

  spi_host_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(OFS_STAT, s);
      if (s == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(OFS_STAT, d); chk("R1 status", d, 0);
    rd(OFS_TXLV, d); chk("R1 txlevel", d, 0);
    rd(OFS_RXLV, d); chk("R1 rxlevel", d, 0);
  endtask

  task automatic t_cfg_lock();
    logic [31:0] d;
    wr(OFS_CTRL, 32'hC0); wr(OFS_DIV, 32'd8);
    rd(OFS_CTRL, d); chk("R2 ctrl readback", d, 32'hC0);
    wr(OFS_EN, 1);
    wr(OFS_CTRL, 32'h0); wr(OFS_DIV, 32'd4);
    rd(OFS_CTRL, d); chk("R2 ctrl locked", d, 32'hC0);
    rd(OFS_DIV, d);  chk("R2 div locked", d, 32'd8);
    wr(OFS_EN, 0);
    wr(OFS_CTRL, 32'h0); wr(OFS_DIV, 32'd2);
    rd(OFS_CTRL, d); chk("R2 ctrl after disable", d, 0);
  endtask

  task automatic t_wm();
    logic [31:0] d;
    wr(OFS_TXWM, 31); rd(OFS_TXWM, d); chk("R3 tx wm 31", d, 31);
    wr(OFS_TXWM, 32); rd(OFS_TXWM, d); chk("R3 tx wm 32 rejected", d, 31);
    wr(OFS_RXWM, 40); rd(OFS_RXWM, d); chk("R3 rx wm 40 rejected", d, 0);
    wr(OFS_TXWM, 0);
  endtask

  task automatic t_cs();
    wr(OFS_SEL, 32'h5); chk("R10 cs_n 0101", 32'(cs_n), 32'hA);
    wr(OFS_SEL, 32'h0); chk("R10 cs_n none", 32'(cs_n), 32'hF);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    wr(OFS_TXD, 32'h11);
    repeat (100) @(negedge clk);
    rd(OFS_TXLV, d); chk("R13 held while off", d, 1);
    rd(OFS_RXLV, d); chk("R13 no rx while off", d, 0);
    rd(OFS_STAT, d); chk("R11 busy with queued byte", d, 1);
    wr(OFS_EN, 1); wait_idle();
    rd(OFS_RXLV, d); chk("R13 shifted after enable", d, 1);
    rd(OFS_RXD, d); chk("R9 byte back", d, 32'h11);
    wr(OFS_EN, 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 33; i++) wr(OFS_TXD, 32'h40 + i);
    rd(OFS_TXLV, d); chk("R4 tx level capped", d, 32);
    wr(OFS_EN, 1);
    rd(OFS_STAT, d); chk("R11 busy while shifting", d, 1);
    wait_idle();
    rd(OFS_RXLV, d); chk("R9 one rx per tx", d, 32);
    for (int i = 0; i < 32; i++) begin
      rd(OFS_RXD, d); chk("R9 rx order", d, 32'h40 + i);
    end
    rd(OFS_RXD, d); chk("R5 empty read zero", d, 0);
    rd(OFS_STAT, d); chk("R11 idle", d, 0);
    wr(OFS_EN, 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      wr(OFS_CTRL, (m[1] ? 32'h80 : 0) | (m[0] ? 32'h40 : 0));
      wr(OFS_EN, 1);
      repeat (2) @(negedge clk);
      chk("R7 idle level", 32'(sclk), 32'(m[1]));
      invert = (m == 2);
      wr(OFS_TXD, 32'h96 + m);
      wait_idle();
      rd(OFS_RXD, d);
      chk("R7 loop byte", d, invert ? 32'(8'(~(8'h96 + m))) : 32'h96 + m);
      chk("R7 idle after frame", 32'(sclk), 32'(m[1]));
      wr(OFS_EN, 0);
    end
    invert = 1'b0;
    wr(OFS_CTRL, 0);
  endtask

  task automatic t_msb();
    logic [7:0] got = '0;
    logic prev;
    int n = 0;
    wr(OFS_EN, 1);
    wr(OFS_TXD, 32'hA5);
    prev = sclk;
    for (int i = 0; i < 400 && n < 8; i++) begin
      @(negedge clk);
      if (!prev && sclk) begin got = {got[6:0], mosi}; n++; end
      prev = sclk;
    end
    chk("R8 msb first", 32'(got), 32'hA5);
    wait_idle();
    begin logic [31:0] d; rd(OFS_RXD, d); end
    wr(OFS_EN, 0);
  endtask

  task automatic t_div(input logic [31:0] dv, input int exp_half);
    logic prev;
    int h = 0;
    bit seen = 0;
    wr(OFS_DIV, dv);
    wr(OFS_EN, 1);
    wr(OFS_TXD, 32'h3C);
    prev = sclk;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (seen) h++;
      if (sclk != prev) begin
        if (seen) break;
        seen = 1;
      end
      prev = sclk;
    end
    chk("R6 half period", 32'(h), 32'(exp_half));
    wait_idle();
    begin logic [31:0] d; rd(OFS_RXD, d); end
    wr(OFS_EN, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(OFS_MASK, 32'h11);
    wr(OFS_CLR, 32'h11);
    rd(OFS_MSTAT, d); chk("R12 tx low latched", d, 32'h01);
    repeat (2) @(negedge clk);
    chk("R12 irq high", 32'(irq), 1);
    wr(OFS_RXWM, 1);
    wr(OFS_MASK, 32'h10);
    wr(OFS_EN, 1);
    wr(OFS_TXD, 32'h01); wr(OFS_TXD, 32'h02);
    wait_idle();
    rd(OFS_MSTAT, d); chk("R12 rx above wm", d, 32'h10);
    rd(OFS_RAW, d);   chk("R12 raw both", d, 32'h11);
    rd(OFS_RXD, d); rd(OFS_RXD, d);
    rd(OFS_MSTAT, d); chk("R12 still latched", d, 32'h10);
    wr(OFS_CLR, 32'h10);
    rd(OFS_MSTAT, d); chk("R12 cleared", d, 0);
    repeat (2) @(negedge clk);
    chk("R12 irq low", 32'(irq), 0);
    wr(OFS_EN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_cfg_lock();
    t_wm();
    t_cs();
    t_enable_gate();
    t_full();
    t_modes();
    t_msb();
    t_div(32'd6, 3);
    t_div(32'd7, 3);
    t_div(32'd0, 1);
    t_div(32'd10, 5);
    wr(OFS_DIV, 2);
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule